// File: doc/BRIEF.md
# Stop-Mode On-Demand Oscillator Clock Gate

This block controls clock enables for a chip while it sits in a low-power stop state. When the stop state is entered, every clock enable in the core power domain is dropped. The enables of all four oscillators are dropped as well: the phase-locked loop, the multi-speed oscillator, the internal high-speed oscillator and the external crystal oscillator. A small fixed set of wakeup-capable serial receivers can still ask for the internal high-speed oscillator while the chip is stopped. The block turns that oscillator on only while at least one of them is asking. It passes the resulting clock only to the receivers that asked for it.

Each receiver raises its request line while it is taking in a frame. If the frame is not a wakeup frame, the receiver drops the request when the frame ends. If the frame is a wakeup frame, the receiver raises its wakeup flag while its request is still up. The block then pulses a wakeup output, returns to run mode and turns every clock enable back on. The block has no reset output, so state held in memories and registers is left untouched on stop entry and on stop exit.

Top module: `stop_clk_gate`

## Requirements
- R1: After reset the block is in run mode. Every bit of `core_clk_en_o`, `osc_en_o` and `periph_clk_en_o` is 1, and `wakeup_o` is 0.
- R2: A `stop_enter_i` sampled in run mode puts the block in stop mode from the next cycle. In stop mode all `core_clk_en_o` bits are 0. `osc_en_o` bits 0 (loop), 1 (multi-speed) and 3 (crystal) are also 0.
- R3: In stop mode, `osc_en_o` bit 2 (high-speed internal) is 1 in a cycle only if the block was already in stop mode at the previous edge, and at least one `req_i` bit was sampled high at that edge. Otherwise it is 0.
- R4: In stop mode, `periph_clk_en_o[i]` is 1 only if `req_i[i]` was sampled high at the previous edge while bit 2 of `osc_en_o` was already 1. Peripherals that did not request never receive an enable.
- R5: On the first request after a period with no requests, bit 2 of `osc_en_o` rises exactly one cycle before the requester's `periph_clk_en_o` bit.
- R6: When a receiver drops its request (a frame that is not a wakeup frame), its `periph_clk_en_o` bit falls in the next cycle. Once no requests remain, bit 2 of `osc_en_o` falls in the next cycle.
- R7: A cycle in stop mode with `req_i[i]` and `wake_i[i]` both high for some i produces a one-cycle pulse on `wakeup_o` in the next cycle. In that same next cycle the block is back in run mode with all enables at 1.
- R8: A `stop_exit_i` sampled in stop mode returns the block to run mode, with all enables at 1 from the next cycle. `stop_enter_i` has no effect while the block is in stop mode.
- R9: In run mode, `req_i`, `wake_i` and `stop_exit_i` are ignored: all enables stay at 1 and `wakeup_o` stays 0.
- R10: If `stop_enter_i` and `stop_exit_i` are both sampled high in run mode, the block enters stop mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_enter_i | input | 1 | Request to enter stop mode |
| stop_exit_i | input | 1 | Request to leave stop mode |
| req_i | input | N_REQ (5) | Per-receiver request for the high-speed internal oscillator |
| wake_i | input | N_REQ (5) | Per-receiver flag: the frame in progress is a wakeup frame |
| osc_en_o | output | 4 | Oscillator enables: bit 0 loop, bit 1 multi-speed, bit 2 high-speed internal, bit 3 crystal |
| core_clk_en_o | output | N_CORE (8) | Core-domain clock enables |
| periph_clk_en_o | output | N_REQ (5) | Per-receiver gated high-speed clock enables |
| wakeup_o | output | 1 | One-cycle pulse on a wakeup frame in stop mode |

## Verification
The bench targets the start-up order. A design that gated the clock through in the same cycle the oscillator came on would show a receiver enable with no oscillator enable in the cycle before it. It also targets the first stop cycle with a request already held, where a design that looked at the request too early would turn the oscillator on one cycle sooner than expected. Other cases covered are a wakeup flag raised by a receiver that has no request (it must not wake the block), enter and exit requested together, and requests arriving in run mode. A design that let requests through in run mode, or that woke on an unqualified flag, would show wrong enables or a stray wakeup pulse. Random traffic mixes overlapping requests, drops and wakeups, and compares every output in every cycle against a reference model.

// File: rtl/scg_pkg.sv
package scg_pkg;
  localparam int OSC_W   = 4;
  localparam int OSC_PLL = 0;
  localparam int OSC_MSI = 1;
  localparam int OSC_HSI = 2;
  localparam int OSC_HSE = 3;

  typedef enum logic {
    MODE_RUN  = 1'b0,
    MODE_STOP = 1'b1
  } mode_e;

  // Oscillator enable vector for a given mode and high-speed request state.
  function automatic logic [OSC_W-1:0] osc_vec(input logic stopped, input logic hsi_on);
    logic [OSC_W-1:0] v;
    if (!stopped) begin
      v = '1;
    end else begin
      v = '0;
      v[OSC_HSI] = hsi_on;
    end
    return v;
  endfunction

  // Next mode from the current mode and the qualified events.
  function automatic mode_e next_mode(input mode_e cur, input logic enter,
                                      input logic leave);
    mode_e n;
    n = cur;
    if (cur == MODE_RUN && enter) n = MODE_STOP;
    if (cur == MODE_STOP && leave) n = MODE_RUN;
    return n;
  endfunction
endpackage

// File: rtl/scg_mode_fsm.sv
module scg_mode_fsm
  import scg_pkg::*;
#(
  parameter int N_REQ = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_enter_i,
  input  logic             stop_exit_i,
  input  logic [N_REQ-1:0] req_i,
  input  logic [N_REQ-1:0] wake_i,
  output logic             in_stop_o,
  output logic             leave_o,
  output logic             wakeup_o
);
  mode_e mode_q;
  logic  wake_hit;
  logic  wakeup_q;

  // A wakeup flag only counts from a receiver that holds a request.
  assign in_stop_o = (mode_q == MODE_STOP);
  assign wake_hit  = in_stop_o && (|(req_i & wake_i));
  assign leave_o   = in_stop_o && (wake_hit || stop_exit_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_RUN;
      wakeup_q <= 1'b0;
    end else begin
      mode_q   <= next_mode(mode_q, stop_enter_i, leave_o);
      wakeup_q <= wake_hit;
    end
  end

  assign wakeup_o = wakeup_q;
endmodule

// File: rtl/scg_hsi_arb.sv
module scg_hsi_arb #(
  parameter int N_REQ = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_stop_i,
  input  logic             leave_i,
  input  logic [N_REQ-1:0] req_i,
  output logic             hsi_on_o,
  output logic [N_REQ-1:0] gate_o
);
  logic hold;
  logic hsi_q;

  // Requests are sampled only in stop mode while staying in stop mode.
  assign hold = in_stop_i && !leave_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hsi_q <= 1'b0;
    else        hsi_q <= hold && (|req_i);
  end

  // Each receiver is gated on its own; the gate opens only once the
  // oscillator enable has been up for a cycle.
  for (genvar g = 0; g < N_REQ; g++) begin : g_gate
    logic gate_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gate_q <= 1'b0;
      else        gate_q <= hold && req_i[g] && hsi_q;
    end
    assign gate_o[g] = gate_q;
  end

  assign hsi_on_o = hsi_q;
endmodule

// File: rtl/scg_out_drive.sv
module scg_out_drive
  import scg_pkg::*;
#(
  parameter int N_REQ  = 5,
  parameter int N_CORE = 8
) (
  input  logic              in_stop_i,
  input  logic              hsi_on_i,
  input  logic [N_REQ-1:0]  gate_i,
  output logic [OSC_W-1:0]  osc_en_o,
  output logic [N_CORE-1:0] core_clk_en_o,
  output logic [N_REQ-1:0]  periph_clk_en_o
);
  assign osc_en_o        = osc_vec(in_stop_i, hsi_on_i);
  assign core_clk_en_o   = in_stop_i ? '0 : '1;
  assign periph_clk_en_o = in_stop_i ? gate_i : '1;
endmodule

// File: rtl/stop_clk_gate.sv
module stop_clk_gate
  import scg_pkg::*;
#(
  parameter int N_REQ  = 5,
  parameter int N_CORE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop_enter_i,
  input  logic              stop_exit_i,
  input  logic [N_REQ-1:0]  req_i,
  input  logic [N_REQ-1:0]  wake_i,
  output logic [OSC_W-1:0]  osc_en_o,
  output logic [N_CORE-1:0] core_clk_en_o,
  output logic [N_REQ-1:0]  periph_clk_en_o,
  output logic              wakeup_o
);
  logic             in_stop_w;
  logic             leave_w;
  logic             hsi_on_w;
  logic [N_REQ-1:0] gate_w;

  scg_mode_fsm #(.N_REQ(N_REQ)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .stop_enter_i(stop_enter_i), .stop_exit_i(stop_exit_i),
    .req_i(req_i), .wake_i(wake_i),
    .in_stop_o(in_stop_w), .leave_o(leave_w), .wakeup_o(wakeup_o)
  );

  scg_hsi_arb #(.N_REQ(N_REQ)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .in_stop_i(in_stop_w), .leave_i(leave_w), .req_i(req_i),
    .hsi_on_o(hsi_on_w), .gate_o(gate_w)
  );

  scg_out_drive #(.N_REQ(N_REQ), .N_CORE(N_CORE)) u_drv (
    .in_stop_i(in_stop_w), .hsi_on_i(hsi_on_w), .gate_i(gate_w),
    .osc_en_o(osc_en_o), .core_clk_en_o(core_clk_en_o),
    .periph_clk_en_o(periph_clk_en_o)
  );
endmodule

// File: rtl/scg_checker.sv
module scg_checker
  import scg_pkg::*;
#(
  parameter int N_REQ  = 5,
  parameter int N_CORE = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_stop,
  input logic [N_REQ-1:0]  req_i,
  input logic [OSC_W-1:0]  osc_en_o,
  input logic [N_CORE-1:0] core_clk_en_o,
  input logic [N_REQ-1:0]  periph_clk_en_o,
  input logic              wakeup_o
);
  a_r2_stop_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    in_stop |-> (core_clk_en_o == '0 && !osc_en_o[OSC_PLL] &&
                 !osc_en_o[OSC_MSI] && !osc_en_o[OSC_HSE]));

  a_r3_hsi_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stop && $past(in_stop)) |-> (osc_en_o[OSC_HSI] == $past(|req_i)));

  a_r4_only_requesters: assert property (@(posedge clk) disable iff (!rst_n)
    in_stop |-> ((periph_clk_en_o & ~$past(req_i)) == '0));

  a_r5_osc_before_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stop && |periph_clk_en_o) |-> $past(osc_en_o[OSC_HSI]));

  a_r7_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
    wakeup_o |=> !wakeup_o);

  a_r7_wake_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    wakeup_o |-> !in_stop);

  a_r9_run_all_on: assert property (@(posedge clk) disable iff (!rst_n)
    !in_stop |-> (&core_clk_en_o && &osc_en_o && &periph_clk_en_o));
endmodule

bind stop_clk_gate scg_checker #(.N_REQ(N_REQ), .N_CORE(N_CORE)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_stop(in_stop_w), .req_i(req_i),
  .osc_en_o(osc_en_o), .core_clk_en_o(core_clk_en_o),
  .periph_clk_en_o(periph_clk_en_o), .wakeup_o(wakeup_o)
);

// File: tb/sim_stop_clk_gate.sv
`timescale 1ns/1ps
module sim_stop_clk_gate;
  localparam int NR = 5;
  localparam int NC = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enter = 1'b0, leave = 1'b0;
  logic [NR-1:0] req = '0, wake = '0;
  logic [3:0]    osc;
  logic [NC-1:0] core;
  logic [NR-1:0] periph;
  logic          wup;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // reference model state (values expected after the next edge)
  bit          m_stop = 0, m_osc = 0, m_wake = 0;
  bit [NR-1:0] m_gate = '0;

  always #2.5 clk = ~clk;

  stop_clk_gate #(.N_REQ(NR), .N_CORE(NC)) u0 (
    .clk(clk), .rst_n(rst_n), .stop_enter_i(enter), .stop_exit_i(leave),
    .req_i(req), .wake_i(wake), .osc_en_o(osc), .core_clk_en_o(core),
    .periph_clk_en_o(periph), .wakeup_o(wup)
  );

  function automatic bit [3:0] exp_osc(bit st, bit hs);
    return st ? {1'b0, hs, 2'b00} : 4'b1111;
  endfunction

  function automatic bit [NR-1:0] exp_per(bit st, bit [NR-1:0] g);
    return st ? g : {NR{1'b1}};
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] expv);
    checks++;
    if (got !== expv) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, expv, $time);
    end
  endtask

  task automatic check_all();
    chk("R2 core enables", 32'(core), m_stop ? 32'd0 : 32'hFF);
    chk("R3 oscillator enables", 32'(osc), 32'(exp_osc(m_stop, m_osc)));
    chk("R4 peripheral enables", 32'(periph), 32'(exp_per(m_stop, m_gate)));
    chk("R7 wakeup pulse", 32'(wup), 32'(m_wake));
  endtask

  // Drive one cycle of inputs, advance the model, then compare after the edge.
  task automatic step(bit e, bit x, bit [NR-1:0] r, bit [NR-1:0] w);
    bit hit;
    enter = e; leave = x; req = r; wake = w;
    if (!m_stop) begin
      m_stop = e; m_osc = 0; m_gate = '0; m_wake = 0;
    end else begin
      hit = |(r & w);
      m_wake = hit;
      if (hit || x) begin
        m_stop = 0; m_osc = 0; m_gate = '0;
      end else begin
        m_gate = m_osc ? r : '0;
        m_osc  = |r;
      end
    end
    @(posedge clk);
    @(negedge clk);
    check_all();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 core", 32'(core), 32'hFF);
    chk("R1 osc", 32'(osc), 32'hF);
    chk("R1 periph", 32'(periph), 32'h1F);
    chk("R1 wakeup", 32'(wup), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: run mode ignores requests, wakeup flags and exit
    for (int i = 0; i < 4; i++) step(0, 1, 5'h1F, 5'h1F);
    chk("R9 run periph", 32'(periph), 32'h1F);
    chk("R9 run wakeup", 32'(wup), 0);

    // R10: enter and exit together in run -> stop
    step(1, 1, '0, '0);
    chk("R10 enter wins", 32'(core), 0);
    // R8: enter in stop has no effect
    step(1, 0, '0, '0);
    chk("R8 enter ignored in stop", 32'(core), 0);

    // R5: start-up ordering
    step(0, 0, 5'b00010, '0);
    chk("R5 osc first", 32'(osc), 32'h4);
    chk("R5 gate held", 32'(periph), 0);
    step(0, 0, 5'b00010, '0);
    chk("R5 gate after osc", 32'(periph), 32'h02);
    // R4: second requester while oscillator runs; wake flag without request ignored
    step(0, 0, 5'b01010, 5'b00100);
    chk("R4 added requester", 32'(periph), 32'h0A);
    chk("R4 stray wake flag", 32'(wup), 0);
    // R6: drops
    step(0, 0, 5'b01000, '0);
    chk("R6 one dropped", 32'(periph), 32'h08);
    step(0, 0, '0, '0);
    chk("R6 osc off", 32'(osc), 0);
    chk("R6 gates off", 32'(periph), 0);
    // R8: exit
    step(0, 1, '0, '0);
    chk("R8 exit restores", 32'(osc), 32'hF);

    // R7: wakeup frame
    step(1, 0, 5'b00001, '0);
    step(0, 0, 5'b00001, '0);
    step(0, 0, 5'b00001, 5'b00001);
    chk("R7 wakeup pulse", 32'(wup), 1);
    chk("R7 run restored", 32'(core), 32'hFF);
    step(0, 0, '0, '0);
    chk("R7 single pulse", 32'(wup), 0);

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      bit e, x;
      bit [NR-1:0] r, w;
      e = ($urandom % 8) == 0;
      x = ($urandom % 24) == 0;
      r = NR'($urandom) & NR'($urandom);
      w = (($urandom % 10) == 0) ? NR'($urandom) : '0;
      step(e, x, r, w);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule